// File: doc/BRIEF.md
# Paged SPI Register-File Slave

This block is the control port of a codec-like peripheral. It is an SPI slave in mode 0: SCLK idles low, MOSI is sampled on the rising edge and MISO changes after the falling edge. It holds a bank of 8-bit registers, split into pages of 128 addresses. Every chip-select window opens with a command byte. Bits 7:1 of that byte give a register address and bit 0 gives the direction. A write stores the one data byte that follows. A read returns register contents for as many bytes as the master clocks, and the address advances after every byte. The command byte 0x00 is reserved for selecting a page: the byte after it chooses which page later windows address. Address 0 of every page reads back the current page number.

SCLK, CS_n and MOSI are asynchronous to the system clock and pass through synchronizers, so each SCLK half period must last at least 6 system clocks. A read-modify-write takes two windows: a read window, then a write window.

The controller is a state machine with six states:
- IDLE: chip select is high.
- CMD: waiting for the command byte.
- WDATA: waiting for the data byte of a write.
- PAGE: waiting for the new page number.
- RDATA: streaming register bytes out.
- DROP: ignoring the rest of the window.

Its transitions are:
- IDLE→CMD when the window opens.
- CMD→PAGE on command 0x00.
- CMD→RDATA on a command with bit 0 set.
- CMD→WDATA on any other command.
- WDATA→DROP when the data byte completes, with the register written.
- PAGE→DROP when the page byte completes, with the page taken.
- RDATA→RDATA after each byte, with the address incremented.
- Any state→IDLE when chip select rises.

Top module: `spireg_slave`

## Requirements
- R1: In the first byte of a window, bits 7:1 are the register address and bit 0 selects read (1) or write (0). A command with bit 0 set never writes a register.
- R2: For a write command, the second byte of the window is stored at the addressed register of the current page. Any further bytes in that window are ignored.
- R3: MISO is 0 while chip select is high, during every command byte, and during the data byte of a write window.
- R4: For a read command, the bytes after the command return the addressed register and then the following ones, MSB first. The address wraps from 0x7F to 0x00 within the page, and bursts of at least 52 bytes are supported.
- R5: A window whose command byte is 0x00 takes its next byte as the page number, keeping its low log2(NPAGES) bits. All later windows address that page until it is changed again.
- R6: A read of address 0 returns the current page number, zero-extended.
- R7: Each page holds its own registers. A write in one page does not change the same address in another page.
- R8: Raising chip select ends the window. Any partial byte is discarded, the command decoder restarts, and a partial data or page byte changes nothing.
- R9: After reset, all registers read 0x00, the page is 0 and MISO is 0.
- R10: A read window followed by a write window of a modified value acts as a read-modify-write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock from the master, idle low |
| cs_n | input | 1 | Active-low chip select from the master |
| mosi | input | 1 | Serial data from the master, MSB first |
| miso | output | 1 | Serial data to the master, MSB first |

## Verification
A corrupted address or state register shows up on MISO in the very next read window. It appears as a wrong byte within eight SCLK periods of the command byte, and a burst carries an increment error forward into every later byte. A lost or wrongly latched page is exposed by reading address 0, which returns the page number. A page error also makes a register read back a value written in the other page. A write that leaks from a discarded byte or a read command becomes visible at the next read of that address.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WDATA,
        ST_PAGE,
        ST_RDATA,
        ST_DROP
    } ctl_state_t;
endpackage

// File: rtl/spireg_shifter.sv
module spireg_shifter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sclk,
    input  logic                         cs_n,
    input  logic                         mosi,
    input  logic [spireg_pkg::BYTE_W-1:0] tx_byte,
    output logic                         sel,
    output logic                         rx_valid,
    output logic [spireg_pkg::BYTE_W-1:0] rx_byte,
    output logic                         miso
);
    localparam int BW    = spireg_pkg::BYTE_W;
    localparam int CNT_W = $clog2(BW);

    logic [SYNC_STAGES-1:0] sclk_sy, cs_sy, mosi_sy;
    logic                   sclk_q;
    logic                   sclk_s, mosi_s;
    logic                   rise, fall;
    logic [CNT_W-1:0]       bit_cnt;
    logic [BW-1:0]          rx_sh, tx_sh;

    assign sclk_s = sclk_sy[SYNC_STAGES-1];
    assign mosi_s = mosi_sy[SYNC_STAGES-1];
    assign sel    = ~cs_sy[SYNC_STAGES-1];
    assign rise   = sel & sclk_s & ~sclk_q;
    assign fall   = sel & ~sclk_s & sclk_q;
    assign miso   = tx_sh[BW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_sy  <= '0;
            cs_sy    <= '1;
            mosi_sy  <= '0;
            sclk_q   <= 1'b0;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            sclk_sy  <= {sclk_sy[SYNC_STAGES-2:0], sclk};
            cs_sy    <= {cs_sy[SYNC_STAGES-2:0], cs_n};
            mosi_sy  <= {mosi_sy[SYNC_STAGES-2:0], mosi};
            sclk_q   <= sclk_s;
            rx_valid <= 1'b0;
            if (!sel) begin
                bit_cnt <= '0;
                rx_sh   <= '0;
                tx_sh   <= '0;
            end else begin
                if (rise) begin
                    rx_sh <= {rx_sh[BW-2:0], mosi_s};
                    if (bit_cnt == CNT_W'(BW-1)) begin
                        bit_cnt  <= '0;
                        rx_valid <= 1'b1;
                        rx_byte  <= {rx_sh[BW-2:0], mosi_s};
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (fall) begin
                    if (bit_cnt == '0) begin
                        tx_sh <= tx_byte;
                    end else begin
                        tx_sh <= {tx_sh[BW-2:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spireg_ctrl.sv
module spireg_ctrl #(
    parameter int PAGE_W = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sel,
    input  logic                          rx_valid,
    input  logic [spireg_pkg::BYTE_W-1:0] rx_byte,
    output spireg_pkg::ctl_state_t        state,
    output logic                          wr_en,
    output logic [spireg_pkg::ADDR_W-1:0] addr,
    output logic [spireg_pkg::BYTE_W-1:0] wr_data,
    output logic                          pg_wr,
    output logic [PAGE_W-1:0]             pg_data,
    output logic                          tx_sel
);
    import spireg_pkg::*;

    ctl_state_t        st_q, st_d;
    logic [ADDR_W-1:0] addr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!sel) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_CMD;
                ST_CMD: begin
                    if (rx_valid) begin
                        if (rx_byte == '0)     st_d = ST_PAGE;
                        else if (rx_byte[0])   st_d = ST_RDATA;
                        else                   st_d = ST_WDATA;
                    end
                end
                ST_WDATA: if (rx_valid) st_d = ST_DROP;
                ST_PAGE:  if (rx_valid) st_d = ST_DROP;
                ST_RDATA: st_d = ST_RDATA;
                ST_DROP:  st_d = ST_DROP;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    // address register: latched from the command, advanced per read byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (rx_valid && st_q == ST_CMD) begin
            addr_q <= rx_byte[BYTE_W-1:1];
        end else if (rx_valid && st_q == ST_RDATA) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        state   = st_q;
        addr    = addr_q;
        wr_data = rx_byte;
        pg_data = rx_byte[PAGE_W-1:0];
        wr_en   = sel && rx_valid && (st_q == ST_WDATA);
        pg_wr   = sel && rx_valid && (st_q == ST_PAGE);
        tx_sel  = (st_q == ST_RDATA);
    end

    p_one_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q == ST_DROP || st_q == ST_IDLE));

    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && st_q == ST_RDATA) |=> (addr_q == $past(addr_q) + 1'b1));
endmodule

// File: rtl/spireg_bank.sv
module spireg_bank #(
    parameter int NPAGES = 2,
    parameter int PAGE_W = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sel,
    input  logic                          wr_en,
    input  logic [spireg_pkg::ADDR_W-1:0] addr,
    input  logic [spireg_pkg::BYTE_W-1:0] wr_data,
    input  logic                          pg_wr,
    input  logic [PAGE_W-1:0]             pg_data,
    output logic [spireg_pkg::BYTE_W-1:0] rdata
);
    localparam int DW    = spireg_pkg::BYTE_W;
    localparam int DEPTH = 1 << spireg_pkg::ADDR_W;

    logic [PAGE_W-1:0] page_q;
    logic [DW-1:0]     page_rd [NPAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (pg_wr) begin
            page_q <= pg_data;
        end
    end

    for (genvar p = 0; p < NPAGES; p++) begin : g_page
        logic [DW-1:0] regs [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
            end else if (wr_en && page_q == PAGE_W'(p)) begin
                regs[addr] <= wr_data;
            end
        end

        assign page_rd[p] = regs[addr];
    end

    assign rdata = (addr == '0) ? DW'(page_q) : page_rd[page_q];

    p_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_wr |=> $stable(page_q));

    p_write_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || pg_wr) |-> sel);
endmodule

// File: rtl/spireg_slave.sv
module spireg_slave #(
    parameter int NPAGES      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic miso
);
    import spireg_pkg::*;

    localparam int PAGE_W = (NPAGES > 1) ? $clog2(NPAGES) : 1;

    logic              sel, rx_valid, wr_en, pg_wr, tx_sel;
    logic [BYTE_W-1:0] rx_byte, wr_data, rdata, tx_byte;
    logic [ADDR_W-1:0] addr;
    logic [PAGE_W-1:0] pg_data;
    ctl_state_t        state;

    spireg_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .mosi     (mosi),
        .tx_byte  (tx_byte),
        .sel      (sel),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .miso     (miso)
    );

    spireg_ctrl #(.PAGE_W(PAGE_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .state    (state),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .pg_wr    (pg_wr),
        .pg_data  (pg_data),
        .tx_sel   (tx_sel)
    );

    spireg_bank #(.NPAGES(NPAGES), .PAGE_W(PAGE_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .pg_wr   (pg_wr),
        .pg_data (pg_data),
        .rdata   (rdata)
    );

    assign tx_byte = tx_sel ? rdata : '0;

    p_cmd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD || state == ST_IDLE) |-> !miso);
endmodule

// File: tb/sim_spireg_slave.sv
`timescale 1ns/1ps
module sim_spireg_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    localparam int HALF = 40;

    // vector: [15] page, [14:8] address, [7:0] data
    localparam logic [15:0] VEC [8] = '{
        16'h01A5, 16'h815A, 16'h7F3C, 16'hFFC3,
        16'h40FF, 16'hA201, 16'h1080, 16'h907E
    };

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    spireg_slave u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .cs_n  (cs_n),
        .mosi  (mosi),
        .miso  (miso)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int nbits = 8);
        rx = '0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            mosi = tx[i];
            #HALF;
            sclk = 1'b1;
            rx[i] = miso;
            #HALF;
            sclk = 1'b0;
        end
    endtask

    task automatic win_open();
        cs_n = 1'b0;
        #HALF;
    endtask

    task automatic win_close();
        #HALF;
        cs_n = 1'b1;
        #(2 * HALF);
    endtask

    task automatic set_page(input logic [7:0] p);
        logic [7:0] r;
        win_open();
        xfer(8'h00, r);
        xfer(p, r);
        win_close();
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] r;
        win_open();
        xfer({a, 1'b0}, r);
        xfer(d, r);
        win_close();
    endtask

    task automatic rd_reg(input logic [6:0] a, output logic [7:0] d);
        logic [7:0] r;
        win_open();
        xfer({a, 1'b1}, r);
        xfer(8'h00, d);
        win_close();
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0x00 expected 0x01");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, c, v;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        #20;
        check({7'd0, miso}, 8'h00, "R9 miso after reset");
        rd_reg(7'h05, r); check(r, 8'h00, "R9 register reset");
        rd_reg(7'h00, r); check(r, 8'h00, "R6 page after reset");
        set_page(8'h01);
        rd_reg(7'h7F, r); check(r, 8'h00, "R9 page 1 reset");

        // table walk: page select, write, read back
        for (int k = 0; k < 8; k++) begin
            set_page({7'd0, VEC[k][15]});
            wr_reg(VEC[k][14:8], VEC[k][7:0]);
            rd_reg(VEC[k][14:8], r);
            check(r, VEC[k][7:0], "R2 table readback");
        end

        // page separation and persistence
        set_page(8'h00);
        rd_reg(7'h01, r); check(r, 8'hA5, "R7 page 0 keeps value");
        rd_reg(7'h10, r); check(r, 8'h80, "R7 page 0 addr 0x10");
        set_page(8'h01);
        rd_reg(7'h01, r); check(r, 8'h5A, "R5 page 1 addressed");
        rd_reg(7'h00, r); check(r, 8'h01, "R6 page readback");
        set_page(8'h03);
        rd_reg(7'h00, r); check(r, 8'h01, "R5 page low bits");
        rd_reg(7'h7F, r); check(r, 8'hC3, "R5 page low bits data");

        // burst with wrap in page 0
        set_page(8'h00);
        win_open();
        xfer({7'h7E, 1'b1}, c); check(c, 8'h00, "R3 miso during command");
        xfer(8'h00, r); check(r, 8'h00, "R4 burst 0x7E");
        xfer(8'h00, r); check(r, 8'h3C, "R4 burst 0x7F");
        xfer(8'h00, r); check(r, 8'h00, "R4 wrap to 0x00 page");
        xfer(8'h00, r); check(r, 8'hA5, "R4 wrap to 0x01");
        win_close();

        // long burst of 52 bytes in page 1
        set_page(8'h01);
        for (int i = 0; i < 52; i++) wr_reg(7'(8'h30 + i), 8'(i * 7 + 3));
        win_open();
        xfer({7'h30, 1'b1}, c);
        for (int i = 0; i < 52; i++) begin
            xfer(8'h00, r);
            check(r, 8'(i * 7 + 3), "R4 long burst");
        end
        win_close();

        // extra bytes of a write window are ignored
        set_page(8'h00);
        win_open();
        xfer({7'h05, 1'b0}, c);
        xfer(8'h11, r); check(r, 8'h00, "R3 miso during write data");
        xfer(8'h22, r);
        xfer(8'h33, r);
        win_close();
        rd_reg(7'h05, r); check(r, 8'h11, "R2 first data byte kept");
        rd_reg(7'h06, r); check(r, 8'h00, "R2 no spill to next address");

        // read flag never writes
        win_open();
        xfer({7'h05, 1'b1}, c);
        xfer(8'h99, r); check(r, 8'h11, "R1 read returns value");
        win_close();
        rd_reg(7'h05, r); check(r, 8'h11, "R1 read command did not write");

        // partial bytes discarded
        win_open();
        xfer({7'h05, 1'b0}, c);
        xfer(8'h55, r, 5);
        win_close();
        rd_reg(7'h05, r); check(r, 8'h11, "R8 partial data byte");
        win_open();
        xfer({7'h05, 1'b1}, c, 3);
        win_close();
        rd_reg(7'h05, r); check(r, 8'h11, "R8 decoder restarts");
        win_open();
        xfer(8'h00, c);
        xfer(8'h01, r, 4);
        win_close();
        rd_reg(7'h00, r); check(r, 8'h00, "R8 partial page byte");

        // read-modify-write in two windows
        rd_reg(7'h05, v);
        wr_reg(7'h05, (v & 8'hF0) | (8'h0A & 8'h0F));
        rd_reg(7'h05, r); check(r, 8'h1A, "R10 read-modify-write");
        set_page(8'h01);
        rd_reg(7'h05, r); check(r, 8'h00, "R7 other page untouched");

        // reset clears everything
        #7 rst_n = 1'b0;
        #20 rst_n = 1'b1;
        #20;
        rd_reg(7'h00, r); check(r, 8'h00, "R9 page cleared");
        rd_reg(7'h01, r); check(r, 8'h00, "R9 data cleared");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule